// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single output line. A one-entry holding register takes each written byte, and a separate shift register sends it, so software can queue the next character while the current one is still on the line. Bit timing comes from an external strobe that is high for one clock cycle per bit period. The block has no baud generator of its own.

The frame format is chosen at run time. The character can be seven or eight bits long. Parity can be off, odd or even. One or two stop bits follow. The format inputs are captured when a character's start bit begins, so a frame keeps its format even if the inputs change while it is being sent. A transmit-enable input gates all progress. A status output tells software when the holding register can take another byte.

Top module: `sertx_top`

## Requirements
- R1: After reset the holding register is empty, `empty_o` is 1 and `txd_o` is 1 (idle).
- R2: Each frame is sent in this order: one start bit driven 0, then the data bits least-significant first, then the parity bit if enabled, then the stop bits driven 1. Each bit occupies exactly the interval between two consecutive accepted strobes. A strobe is accepted when `tick_i` and `en_i` are both 1, and the line changes in the cycle after the clock edge that accepts the strobe.
- R3: With `len8_i`=1 a frame carries 8 data bits. With `len8_i`=0 it carries 7 data bits, and bit 7 of the written byte is neither sent nor counted in the parity.
- R4: With `stop2_i`=1 a frame ends with two stop bits. With `stop2_i`=0 it ends with one.
- R5: With `par_en_i`=1 a parity bit follows the data. With `par_odd_i`=1 the total count of ones in the data and parity is odd, and with `par_odd_i`=0 it is even. With `par_en_i`=0 no parity bit is sent and `par_odd_i` has no effect.
- R6: While `en_i` is 0, strobes are ignored and `txd_o` holds its level. The frame resumes where it stopped once `en_i` returns to 1.
- R7: A write (`wr_i`=1) fills the holding register and drives `empty_o` to 0 from the next cycle. Writing during a frame does not disturb the character being shifted.
- R8: `empty_o` returns to 1 in the same cycle that the start bit of the moved character appears on `txd_o`.
- R9: If the holding register is full when the last stop bit ends, the next start bit begins on that same strobe, with no idle bit in between.
- R10: A write while the holding register is full replaces the pending character. Only the last byte written is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Transmit enable |
| tick_i | input | 1 | One-cycle bit-period strobe |
| len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| stop2_i | input | 1 | 1: two stop bits, 0: one |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| wr_i | input | 1 | Holding register write strobe |
| wr_data_i | input | 8 | Byte to transmit |
| empty_o | output | 1 | Holding register empty |
| txd_o | output | 1 | Serial output line |

## Verification
The properties assume that `tick_i` is the only thing that advances the line, and that `en_i` can gate it at any cycle, even in the middle of a bit. The stimulus follows these rules:
- It changes the format inputs only while the line is idle and nothing is pending.
- It never raises `wr_i` in a cycle where `tick_i` is high. This keeps the write and the strobe that takes the byte into the shift register on separate clock edges.
- It drops `en_i` only in the middle of a frame. This exercises the freeze-and-resume behaviour without racing a write.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic len8;
    logic stop2;
    logic par_en;
    logic par_odd;
  } tx_fmt_t;

endpackage

// File: rtl/sertx_rstsync.sv
module sertx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         take_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  logic [W-1:0] data_q, data_n;
  logic         full_q, full_n;

  // A write wins over a take in the same cycle: the old byte leaves
  // and the new byte stays pending.
  always_comb begin
    data_n = data_q;
    full_n = full_q;
    if (wr_i) begin
      data_n = wdata_i;
      full_n = 1'b1;
    end else if (take_i) begin
      full_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_i) data_q <= data_n;
      full_q <= full_n;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  tx_fmt_t      fmt_i,
  input  logic         full_i,
  input  logic [W-1:0] data_i,
  output logic         take_o,
  output logic         txd_o
);
  localparam int CW = $clog2(W + 1);

  tx_state_e    st_q, st_n;
  tx_fmt_t      fmt_q, fmt_n;
  logic [W-1:0] sh_q, sh_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic         par_q, par_n;
  logic         stop_sec_q, stop_sec_n;
  logic         txd_q, txd_n;

  logic          adv;
  logic [W-1:0]  masked;
  logic [CW-1:0] dlen;
  logic          load;

  assign adv    = en_i & tick_i;
  assign masked = fmt_i.len8 ? data_i : {1'b0, data_i[W-2:0]};
  assign dlen   = fmt_q.len8 ? CW'(W) : CW'(W - 1);

  always_comb begin
    st_n       = st_q;
    fmt_n      = fmt_q;
    sh_n       = sh_q;
    cnt_n      = cnt_q;
    par_n      = par_q;
    stop_sec_n = stop_sec_q;
    txd_n      = txd_q;
    load       = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        txd_n = 1'b1;
        if (adv && full_i) load = 1'b1;
      end
      ST_START: begin
        if (adv) begin
          txd_n = sh_q[0];
          sh_n  = sh_q >> 1;
          cnt_n = CW'(1);
          st_n  = ST_DATA;
        end
      end
      ST_DATA: begin
        if (adv) begin
          if (cnt_q == dlen) begin
            if (fmt_q.par_en) begin
              txd_n = par_q;
              st_n  = ST_PAR;
            end else begin
              txd_n      = 1'b1;
              stop_sec_n = 1'b0;
              st_n       = ST_STOP;
            end
          end else begin
            txd_n = sh_q[0];
            sh_n  = sh_q >> 1;
            cnt_n = cnt_q + CW'(1);
          end
        end
      end
      ST_PAR: begin
        if (adv) begin
          txd_n      = 1'b1;
          stop_sec_n = 1'b0;
          st_n       = ST_STOP;
        end
      end
      ST_STOP: begin
        if (adv) begin
          if (fmt_q.stop2 && !stop_sec_q) begin
            stop_sec_n = 1'b1;
          end else if (full_i) begin
            load = 1'b1;
          end else begin
            txd_n = 1'b1;
            st_n  = ST_IDLE;
          end
        end
      end
      default: begin
        txd_n = 1'b1;
        st_n  = ST_IDLE;
      end
    endcase

    // Capture the format and the character when the start bit begins.
    if (load) begin
      st_n  = ST_START;
      txd_n = 1'b0;
      fmt_n = fmt_i;
      sh_n  = masked;
      par_n = (^masked) ^ fmt_i.par_odd;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      fmt_q      <= '0;
      sh_q       <= '0;
      cnt_q      <= '0;
      par_q      <= 1'b0;
      stop_sec_q <= 1'b0;
      txd_q      <= 1'b1;
    end else if (adv) begin
      st_q       <= st_n;
      fmt_q      <= fmt_n;
      sh_q       <= sh_n;
      cnt_q      <= cnt_n;
      par_q      <= par_n;
      stop_sec_q <= stop_sec_n;
      txd_q      <= txd_n;
    end
  end

  assign take_o = load;
  assign txd_o  = txd_q;
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         len8_i,
  input  logic         stop2_i,
  input  logic         par_en_i,
  input  logic         par_odd_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic         empty_o,
  output logic         txd_o
);
  logic         rst_sync_n;
  logic         take;
  logic         full;
  logic [W-1:0] hold_data;
  tx_fmt_t      fmt;

  assign fmt = '{len8: len8_i, stop2: stop2_i, par_en: par_en_i, par_odd: par_odd_i};

  sertx_rstsync #(.STAGES(SYNC_STAGE)) i_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  sertx_hold #(.W(W)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .wr_i    (wr_i),
    .wdata_i (wr_data_i),
    .take_i  (take),
    .data_o  (hold_data),
    .full_o  (full)
  );

  sertx_framer #(.W(W)) i_framer (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (en_i),
    .tick_i (tick_i),
    .fmt_i  (fmt),
    .full_i (full),
    .data_i (hold_data),
    .take_o (take),
    .txd_o  (txd_o)
  );

  assign empty_o = ~full;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk_i,
  input logic rst_n,
  input logic en_i,
  input logic tick_i,
  input logic wr_i,
  input logic take,
  input logic full,
  input logic empty_o,
  input logic txd_o
);
  // R6: with the enable low, the line keeps its level.
  a_r6_hold_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> $stable(txd_o));

  // R2: the line only moves on a strobe.
  a_r2_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tick_i |=> $stable(txd_o));

  // R7 / R10: any write leaves the holding register full.
  a_r7_write_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_i |=> !empty_o);

  // R8: the empty flag comes back together with the start bit.
  a_r8_empty_with_start: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(empty_o) |-> !txd_o);

  // R7: the shifter only takes a character that was written.
  a_r7_take_needs_data: assert property (@(posedge clk_i) disable iff (!rst_n)
    take |-> full);
endmodule

bind sertx_top sertx_chk i_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_sync_n),
  .en_i    (en_i),
  .tick_i  (tick_i),
  .wr_i    (wr_i),
  .take    (take),
  .full    (full),
  .empty_o (empty_o),
  .txd_o   (txd_o)
);

// File: tb/test_sertx_top.sv
`timescale 1ns/1ps
module test_sertx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1, tick = 1'b0;
  logic       len8 = 1'b1, stop2 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       empty, txd;

  int total = 0, bad = 0;
  bit done = 0;
  bit mon_on = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  sertx_top i_sertx_top (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick),
    .len8_i(len8), .stop2_i(stop2), .par_en_i(par_en), .par_odd_i(par_odd),
    .wr_i(wr), .wr_data_i(wdata), .empty_o(empty), .txd_o(txd)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Strobe: one cycle high out of every four.
  initial begin
    forever begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        tick = (i == 3);
      end
    end
  end

  // Driver side: expected line levels, one per accepted strobe.
  task automatic push_frame(input logic [7:0] d, input string start_tag);
    int n;
    logic [7:0] m;
    n = len8 ? 8 : 7;
    m = len8 ? d : {1'b0, d[6:0]};
    exp_q.push_back(1'b0); tag_q.push_back(start_tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(m[i]); tag_q.push_back(len8 ? "R2 data" : "R3 data7");
    end
    if (par_en) begin
      exp_q.push_back((^m) ^ par_odd); tag_q.push_back("R5 parity");
    end
    exp_q.push_back(1'b1); tag_q.push_back("R4 stop1");
    if (stop2) begin
      exp_q.push_back(1'b1); tag_q.push_back("R4 stop2");
    end
  endtask

  task automatic write_byte(input logic [7:0] d, input bit push, input string start_tag);
    @(negedge clk); #1;
    while (tick) begin
      @(negedge clk); #1;
    end
    wr = 1'b1;
    wdata = d;
    if (push) push_frame(d, start_tag);
    @(negedge clk); #1;
    wr = 1'b0;
    check(empty, 1'b0, "R7 empty after write");
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    check(empty, 1'b1, "R7 empty when idle");
    check(txd, 1'b1, "R2 idle high");
  endtask

  task automatic set_fmt(input logic l8, input logic s2, input logic pe, input logic po);
    len8 = l8; stop2 = s2; par_en = pe; par_odd = po;
  endtask

  // Monitor: compares the line at every accepted strobe.
  initial begin
    logic t, frz, last, last_empty, e;
    string g;
    last = 1'b1;
    last_empty = 1'b1;
    forever begin
      @(posedge clk);
      t   = tick & en;
      frz = tick & ~en;
      @(negedge clk);
      if (mon_on) begin
        if (t) begin
          if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            g = tag_q.pop_front();
            check(txd, e, g);
          end else begin
            check(txd, 1'b1, "R2 idle between frames");
          end
        end
        if (frz) check(txd, last, "R6 frozen while disabled");
        if (empty && !last_empty) check(txd, 1'b0, "R8 empty sets with start bit");
      end
      last = txd;
      last_empty = empty;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(empty, 1'b1, "R1 reset empty");
    check(txd, 1'b1, "R1 reset line high");
    mon_on = 1;

    // 8 bits, no parity, one stop
    set_fmt(1, 0, 0, 0);
    write_byte(8'hA5, 1, "R2 start");
    drain();
    // 8 bits, even parity
    set_fmt(1, 0, 1, 0);
    write_byte(8'h3D, 1, "R5 start even");
    drain();
    // 8 bits, odd parity, two stops
    set_fmt(1, 1, 1, 1);
    write_byte(8'h01, 1, "R4 start two-stop");
    drain();
    // 7 bits, even parity: bit 7 dropped
    set_fmt(0, 0, 1, 0);
    write_byte(8'hC5, 1, "R3 start 7-bit");
    drain();
    // 7 bits, parity off, par_odd set (ignored), two stops
    set_fmt(0, 1, 0, 1);
    write_byte(8'h80, 1, "R5 start parity off");
    drain();

    // Back-to-back frames
    set_fmt(1, 0, 1, 1);
    write_byte(8'h55, 1, "R9 first");
    wait (empty == 1'b1);
    write_byte(8'h0F, 1, "R9 next start no gap");
    drain();

    // Overwrite of the pending byte
    set_fmt(1, 1, 0, 0);
    write_byte(8'hF0, 1, "R10 first");
    wait (empty == 1'b1);
    write_byte(8'h11, 0, "R10 discarded");
    write_byte(8'h99, 1, "R10 replacement");
    drain();

    // Enable dropped mid-frame
    set_fmt(1, 0, 1, 0);
    write_byte(8'h6B, 1, "R6 start");
    repeat (14) @(negedge clk);
    en = 1'b0;
    repeat (16) @(negedge clk);
    en = 1'b1;
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule